// File: doc/BRIEF.md
# Pin-Multiplexed Memory Test Port

This block links a narrow external test port to several embedded DRAM macros. The port carries a test-mode entry pin, a 5-bit command and an 18-bit shared field. That field holds a row address, a column address with write data, or a subcommand, depending on the command presented with it. The block decodes each command and joins the row half and the column half of the address, which arrive in separate port cycles. It then issues a single-cycle strobe on an internal test bus, with the operation, the full address and a 9-bit write word (8 data bits plus an even parity bit).

A stored macro selection decides which one macro is enabled. The 9-bit read word returned on the data output comes from that macro only. The parity of each read word is checked, and a sticky parity-error flag and a sticky illegal-command flag can be read back through a status subcommand. The DRAM arrays, their timing and any pattern generation sit outside the block.

Top module: `memtest_port`

## Requirements
- R1: While `tm_en` is low, commands are ignored. From the first clock edge that samples `tm_en` low, `macro_en` is all zero, `bus_valid` is low and `dout` is zero. The row latch, the selection (back to macro 0), the long-word arming and both flags are cleared.
- R2: Command 1 (ROW) latches `field[11:0]` as the row. Command 2 (READ) and command 3 (WRITE) take the column from `field[9:0]`. In the cycle after the access command is sampled, `bus_valid` is high and `bus_addr` = {row, column}, with the row in bits 21:10.
- R3: `bus_op` encodes READ as 1, WRITE as 2 and PRECHARGE as 3. Command 4 (PRECHARGE) issues a strobe with `bus_addr` = {row, 10'b0}.
- R4: WRITE takes its data from `field[17:10]`. `bus_wdata[7:0]` carries that data and `bus_wdata[8]` is the XOR of those 8 bits, so the 9-bit word has even parity.
- R5: The selected macro's 9-bit word, sampled at the second edge after the edge that raised a READ strobe, appears on `dout` after that edge. If the word has odd parity, a sticky parity-error flag is set.
- R6: Command 5 (LONG) makes the next port cycle a subcommand cycle: the command pins are ignored, and the subcommand code is `field[17:15]`. Subcommand 1 (SELECT) selects macro `field[1:0]`. `macro_en` is the one-hot of the selection, and after test-mode entry macro 0 is selected.
- R7: `dout` carries only the selected macro's read word. Words from other macros never reach it.
- R8: Subcommand 2 (STATUS) puts {7'b0, illegal flag, parity flag} on `dout` after its edge. A read capture at the same edge takes priority over it. Subcommand 3 (CLEAR) clears both flags, but a flag set at the same edge stays set.
- R9: Command codes 6 to 31, subcommand codes 0 and 4 to 7, and a SELECT index of NUM_MACROS or more produce no strobe and change no selection. Each of them sets the sticky illegal flag.
- R10: After reset, `bus_valid`, `macro_en` and `dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tm_en | input | 1 | Test-mode entry |
| cmd | input | 5 | Port command code |
| field | input | 18 | Shared row / column+data / subcommand field |
| mrd_bus | input | NUM_MACROS*9 | Read words from all macros, macro i at bits [9i+8:9i] |
| bus_valid | output | 1 | Single-cycle test bus strobe |
| bus_op | output | 2 | Test bus operation code |
| bus_addr | output | 22 | Assembled {row, column} address |
| bus_wdata | output | 9 | Write word with even-parity bit 8 |
| macro_en | output | NUM_MACROS | One-hot enable of the selected macro |
| dout | output | 9 | Read word or status word |

## Verification
The bench writes different words into two macros at the same address, then switches the selection. A mux that ignored the selection would return the other macro's word. It corrupts the parity bit of one returned word and reads the status back, and it clears the flags in the same edge that captures a bad word, so a design that let CLEAR win would show zero. It places a STATUS subcommand on the edge that captures a read, where the wrong priority would show the status word in place of the data. It drops test mode after changing the row and the selection, so a design that kept stale state would issue the wrong address or enable the wrong macro after re-entry.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

   localparam int unsigned CMD_W = 5;
   localparam int unsigned SUB_W = 3;

   localparam logic [CMD_W-1:0] CMD_NOP   = 5'd0;
   localparam logic [CMD_W-1:0] CMD_ROW   = 5'd1;
   localparam logic [CMD_W-1:0] CMD_READ  = 5'd2;
   localparam logic [CMD_W-1:0] CMD_WRITE = 5'd3;
   localparam logic [CMD_W-1:0] CMD_PRE   = 5'd4;
   localparam logic [CMD_W-1:0] CMD_LONG  = 5'd5;

   localparam logic [SUB_W-1:0] SUB_SEL   = 3'd1;
   localparam logic [SUB_W-1:0] SUB_STAT  = 3'd2;
   localparam logic [SUB_W-1:0] SUB_CLR   = 3'd3;

   typedef enum logic [1:0] {
      BOP_NONE  = 2'd0,
      BOP_READ  = 2'd1,
      BOP_WRITE = 2'd2,
      BOP_PRE   = 2'd3
   } bus_op_e;

endpackage

// File: rtl/mtp_decode.sv
module mtp_decode
   import mtp_pkg::*;
#(
   parameter int NUM_MACROS = 3,
   parameter int MSEL_W     = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tm_en,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [SUB_W-1:0]  sub_code,
   input  logic [MSEL_W-1:0] sub_idx,
   output logic              row_ld,
   output bus_op_e           acc_op,
   output logic              sel_ld,
   output logic [MSEL_W-1:0] sel_idx,
   output logic              stat_rd,
   output logic              flag_clr,
   output logic              ill_hit
);

   logic armed_q;

   // a LONG command arms exactly one following cycle as a subcommand cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else
         armed_q <= tm_en && !armed_q && (cmd == CMD_LONG);
   end

   assign sel_idx = sub_idx;

   always_comb begin
      row_ld   = 1'b0;
      acc_op   = BOP_NONE;
      sel_ld   = 1'b0;
      stat_rd  = 1'b0;
      flag_clr = 1'b0;
      ill_hit  = 1'b0;
      if (tm_en) begin
         if (armed_q) begin
            case (sub_code)
               SUB_SEL: begin
                  if (int'(sub_idx) < NUM_MACROS) sel_ld  = 1'b1;
                  else                            ill_hit = 1'b1;
               end
               SUB_STAT: stat_rd  = 1'b1;
               SUB_CLR:  flag_clr = 1'b1;
               default:  ill_hit  = 1'b1;
            endcase
         end else begin
            case (cmd)
               CMD_NOP:   ;
               CMD_LONG:  ;
               CMD_ROW:   row_ld = 1'b1;
               CMD_READ:  acc_op = BOP_READ;
               CMD_WRITE: acc_op = BOP_WRITE;
               CMD_PRE:   acc_op = BOP_PRE;
               default:   ill_hit = 1'b1;
            endcase
         end
      end
   end

   // R6: a subcommand cycle never also starts an access
   assert_sub_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (acc_op == BOP_NONE && !row_ld));

endmodule

// File: rtl/mtp_busgen.sv
module mtp_busgen
   import mtp_pkg::*;
#(
   parameter int ROW_W  = 12,
   parameter int COL_W  = 10,
   parameter int DATA_W = 8,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int WORD_W = DATA_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tm_en,
   input  logic              row_ld,
   input  bus_op_e           acc_op,
   input  logic [ROW_W-1:0]  row_bits,
   input  logic [COL_W-1:0]  col_bits,
   input  logic [DATA_W-1:0] data_bits,
   output logic              bus_valid,
   output bus_op_e           bus_op,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [WORD_W-1:0] bus_wdata
);

   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_sel;

   assign col_sel = (acc_op == BOP_PRE) ? '0 : col_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q     <= '0;
         bus_valid <= 1'b0;
         bus_op    <= BOP_NONE;
         bus_addr  <= '0;
         bus_wdata <= '0;
      end else if (!tm_en) begin
         row_q     <= '0;
         bus_valid <= 1'b0;
         bus_op    <= BOP_NONE;
      end else begin
         bus_valid <= (acc_op != BOP_NONE);
         bus_op    <= acc_op;
         if (row_ld)
            row_q <= row_bits;
         if (acc_op != BOP_NONE)
            bus_addr <= {row_q, col_sel};
         if (acc_op == BOP_WRITE)
            bus_wdata <= {^data_bits, data_bits};
      end
   end

   // R2: the row half of an issued address is the currently latched row
   assert_addr_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_addr[ADDR_W-1:COL_W] == row_q));

   // R4: every write word leaves with even parity
   assert_wdata_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_op == BOP_WRITE) |-> (^bus_wdata == 1'b0));

   // R1: no strobe once test mode has been sampled low
   assert_no_strobe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tm_en |=> !bus_valid);

endmodule

// File: rtl/mtp_select.sv
module mtp_select
   import mtp_pkg::*;
#(
   parameter int NUM_MACROS = 3,
   parameter int MSEL_W     = 2,
   parameter int WORD_W     = 9
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tm_en,
   input  logic                         sel_ld,
   input  logic [MSEL_W-1:0]            sel_idx,
   input  logic                         stat_rd,
   input  logic                         flag_clr,
   input  logic                         ill_hit,
   input  logic                         bus_valid,
   input  bus_op_e                      bus_op,
   input  logic [NUM_MACROS*WORD_W-1:0] mrd_bus,
   output logic [NUM_MACROS-1:0]        macro_en,
   output logic [WORD_W-1:0]            dout
);

   logic              tm_act;
   logic [MSEL_W-1:0] sel_q;
   logic              rd_wait;
   logic              perr_q;
   logic              ill_q;
   logic [WORD_W-1:0] words [NUM_MACROS];
   logic [WORD_W-1:0] picked;
   logic              bad_word;

   for (genvar i = 0; i < NUM_MACROS; i++) begin : g_slice
      assign words[i]    = mrd_bus[i*WORD_W +: WORD_W];
      assign macro_en[i] = tm_act && (sel_q == MSEL_W'(i));
   end

   if (NUM_MACROS == 1) begin : g_single
      assign picked = words[0];
   end else begin : g_mux
      always_comb begin
         picked = '0;
         for (int i = 0; i < NUM_MACROS; i++)
            if (sel_q == MSEL_W'(i)) picked = words[i];
      end
   end

   assign bad_word = rd_wait && (^picked);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tm_act  <= 1'b0;
         sel_q   <= '0;
         rd_wait <= 1'b0;
         perr_q  <= 1'b0;
         ill_q   <= 1'b0;
         dout    <= '0;
      end else if (!tm_en) begin
         tm_act  <= 1'b0;
         sel_q   <= '0;
         rd_wait <= 1'b0;
         perr_q  <= 1'b0;
         ill_q   <= 1'b0;
         dout    <= '0;
      end else begin
         tm_act  <= 1'b1;
         rd_wait <= bus_valid && (bus_op == BOP_READ);
         if (sel_ld)
            sel_q <= sel_idx;
         perr_q <= bad_word || (perr_q && !flag_clr);
         ill_q  <= ill_hit  || (ill_q  && !flag_clr);
         if (rd_wait)
            dout <= picked;
         else if (stat_rd)
            dout <= WORD_W'({ill_q, perr_q});
      end
   end

   // R6: at most one macro is enabled at any time
   assert_single_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(macro_en));

   // R1: enables and output drop after test mode is sampled low
   assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tm_en |=> (macro_en == '0 && dout == '0));

   // R5: a captured word of odd parity raises the flag
   assert_perr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tm_en && bad_word) |=> perr_q);

   // R5: the parity flag is sticky until cleared or test mode ends
   assert_perr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_q && tm_en && !flag_clr) |=> perr_q);

   // R9: an illegal code always leaves the illegal flag set
   assert_ill_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tm_en && ill_hit) |=> ill_q);

endmodule

// File: rtl/memtest_port.sv
module memtest_port
   import mtp_pkg::*;
#(
   parameter int NUM_MACROS = 3,
   parameter int FIELD_W    = 18,
   parameter int ROW_W      = 12,
   parameter int COL_W      = 10,
   parameter int DATA_W     = 8,
   localparam int ADDR_W    = ROW_W + COL_W,
   localparam int WORD_W    = DATA_W + 1,
   localparam int MSEL_W    = (NUM_MACROS > 1) ? $clog2(NUM_MACROS) : 1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tm_en,
   input  logic [CMD_W-1:0]             cmd,
   input  logic [FIELD_W-1:0]           field,
   input  logic [NUM_MACROS*WORD_W-1:0] mrd_bus,
   output logic                         bus_valid,
   output logic [1:0]                   bus_op,
   output logic [ADDR_W-1:0]            bus_addr,
   output logic [WORD_W-1:0]            bus_wdata,
   output logic [NUM_MACROS-1:0]        macro_en,
   output logic [WORD_W-1:0]            dout
);

   if (NUM_MACROS < 1) begin : g_bad_count
      $error("memtest_port: NUM_MACROS must be at least 1");
   end
   if (ROW_W > FIELD_W) begin : g_bad_row
      $error("memtest_port: row does not fit the shared field");
   end
   if (COL_W + DATA_W > FIELD_W) begin : g_bad_wr
      $error("memtest_port: column plus data exceed the shared field");
   end
   if (MSEL_W + SUB_W > FIELD_W) begin : g_bad_sub
      $error("memtest_port: subcommand and index overlap");
   end

   logic              row_ld;
   bus_op_e           acc_op;
   logic              sel_ld;
   logic [MSEL_W-1:0] sel_idx;
   logic              stat_rd;
   logic              flag_clr;
   logic              ill_hit;
   bus_op_e           bus_op_i;

   mtp_decode #(.NUM_MACROS(NUM_MACROS), .MSEL_W(MSEL_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .tm_en    (tm_en),
      .cmd      (cmd),
      .sub_code (field[FIELD_W-1 -: SUB_W]),
      .sub_idx  (field[MSEL_W-1:0]),
      .row_ld   (row_ld),
      .acc_op   (acc_op),
      .sel_ld   (sel_ld),
      .sel_idx  (sel_idx),
      .stat_rd  (stat_rd),
      .flag_clr (flag_clr),
      .ill_hit  (ill_hit)
   );

   mtp_busgen #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .tm_en     (tm_en),
      .row_ld    (row_ld),
      .acc_op    (acc_op),
      .row_bits  (field[ROW_W-1:0]),
      .col_bits  (field[COL_W-1:0]),
      .data_bits (field[COL_W +: DATA_W]),
      .bus_valid (bus_valid),
      .bus_op    (bus_op_i),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata)
   );

   mtp_select #(.NUM_MACROS(NUM_MACROS), .MSEL_W(MSEL_W), .WORD_W(WORD_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .tm_en     (tm_en),
      .sel_ld    (sel_ld),
      .sel_idx   (sel_idx),
      .stat_rd   (stat_rd),
      .flag_clr  (flag_clr),
      .ill_hit   (ill_hit),
      .bus_valid (bus_valid),
      .bus_op    (bus_op_i),
      .mrd_bus   (mrd_bus),
      .macro_en  (macro_en),
      .dout      (dout)
   );

   assign bus_op = bus_op_i;

   // R9: an illegal code issues no strobe in the following cycle
   assert_illegal_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ill_hit |=> !bus_valid);

endmodule

// File: tb/sim_memtest_port.sv
module sim_memtest_port;

   localparam int NM = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tm_en = 1'b0;
   logic [4:0]   cmd = '0;
   logic [17:0]  field = '0;
   logic [NM*9-1:0] mrd_bus;
   logic         bus_valid;
   logic [1:0]   bus_op;
   logic [21:0]  bus_addr;
   logic [8:0]   bus_wdata;
   logic [NM-1:0] macro_en;
   logic [8:0]   dout;

   int total = 0;
   int fails = 0;
   bit started = 1'b0;
   bit inject = 1'b0;

   always #2.5 clk = ~clk;

   memtest_port #(.NUM_MACROS(NM)) u0 (
      .clk(clk), .rst_n(rst_n), .tm_en(tm_en), .cmd(cmd), .field(field),
      .mrd_bus(mrd_bus), .bus_valid(bus_valid), .bus_op(bus_op),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .macro_en(macro_en), .dout(dout)
   );

   // macro models: 16 words each, read word returned one edge after the strobe
   logic [8:0] mem [NM][16];
   logic [8:0] mrd [NM];

   initial begin
      for (int m = 0; m < NM; m++) begin
         mrd[m] = '0;
         for (int a = 0; a < 16; a++) mem[m][a] = '0;
      end
   end

   always_comb
      for (int m = 0; m < NM; m++) mrd_bus[m*9 +: 9] = mrd[m];

   always @(posedge clk)
      for (int m = 0; m < NM; m++)
         if (bus_valid && macro_en[m]) begin
            if (bus_op == 2'd2) mem[m][bus_addr[3:0]] <= bus_wdata;
            if (bus_op == 2'd1) mrd[m] <= mem[m][bus_addr[3:0]] ^ (inject ? 9'h100 : 9'h000);
         end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model, evaluated on every rising edge
   int m_act, m_sel, m_row, m_arm, m_val, m_op, m_addr, m_wd, m_rdw, m_dout, m_perr, m_ill;
   initial begin
      m_act = 0; m_sel = 0; m_row = 0; m_arm = 0; m_val = 0; m_op = 0;
      m_addr = 0; m_wd = 0; m_rdw = 0; m_dout = 0; m_perr = 0; m_ill = 0;
   end

   always @(posedge clk) begin
      int cap, stat, clr, ill, nxt_val, nxt_op, nxt_arm, d;
      started <= 1'b1;
      if (!rst_n || !tm_en) begin
         m_act = 0; m_sel = 0; m_row = 0; m_arm = 0; m_val = 0; m_op = 0;
         m_rdw = 0; m_dout = 0; m_perr = 0; m_ill = 0;
      end else begin
         cap = m_rdw;
         m_rdw = (m_val != 0 && m_op == 1) ? 1 : 0;
         stat = 0; clr = 0; ill = 0; nxt_val = 0; nxt_op = 0; nxt_arm = 0;
         if (m_arm != 0) begin
            case (int'(field[17:15]))
               1: if (int'(field[1:0]) < NM) m_sel = int'(field[1:0]); else ill = 1;
               2: stat = 1;
               3: clr = 1;
               default: ill = 1;
            endcase
         end else begin
            case (int'(cmd))
               0: ;
               1: m_row = int'(field[11:0]);
               2: begin nxt_val = 1; nxt_op = 1; m_addr = m_row * 1024 + int'(field[9:0]); end
               3: begin
                     nxt_val = 1; nxt_op = 2; m_addr = m_row * 1024 + int'(field[9:0]);
                     d = int'(field[17:10]);
                     m_wd = d + ($countones(d) % 2) * 256;
                  end
               4: begin nxt_val = 1; nxt_op = 3; m_addr = m_row * 1024; end
               5: nxt_arm = 1;
               default: ill = 1;
            endcase
         end
         if (cap != 0) m_dout = int'(mrd[m_sel]);
         else if (stat != 0) m_dout = m_ill * 2 + m_perr;
         if (clr != 0) begin m_perr = 0; m_ill = 0; end
         if (ill != 0) m_ill = 1;
         if (cap != 0 && ($countones(mrd[m_sel]) % 2) == 1) m_perr = 1;
         m_val = nxt_val; m_op = nxt_op; m_arm = nxt_arm; m_act = 1;
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (started) begin
         chk("R6 macro_en", int'(macro_en), (m_act != 0) ? (1 << m_sel) : 0);
         chk("R2 bus_valid", int'(bus_valid), m_val);
         chk("R5 dout", int'(dout), m_dout);
         if (m_val != 0) begin
            chk("R3 bus_op", int'(bus_op), m_op);
            chk("R2 bus_addr", int'(bus_addr), m_addr);
            if (m_op == 2) chk("R4 bus_wdata", int'(bus_wdata), m_wd);
         end
      end
   end

   task automatic cyc(input logic [4:0] c, input logic [17:0] f);
      cmd = c;
      field = f;
      @(negedge clk);
   endtask

   task automatic rd(input int col);
      cyc(5'd2, 18'(col));
      cyc(5'd0, 18'd0);
      cyc(5'd0, 18'd0);
   endtask

   task automatic sub(input int code, input int arg);
      cyc(5'd5, 18'd0);
      cyc(5'd0, 18'(code * 32768 + arg));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 bus_valid after reset", int'(bus_valid), 0);
      chk("R10 macro_en after reset", int'(macro_en), 0);
      chk("R10 dout after reset", int'(dout), 0);
      rst_n = 1'b1;
      tm_en = 1'b1;
      cyc(5'd0, 18'd0);
      chk("R6 default select", int'(macro_en), 1);

      cyc(5'd1, 18'h000A5);
      cyc(5'd3, {8'h5A, 10'd3});
      chk("R2 write strobe", int'(bus_valid), 1);
      chk("R3 write op", int'(bus_op), 2);
      chk("R2 write addr", int'(bus_addr), 32'h29403);
      chk("R4 even word", int'(bus_wdata), 32'h05A);
      cyc(5'd3, {8'h07, 10'd4});
      chk("R4 odd data", int'(bus_wdata), 32'h107);
      rd(3);
      chk("R5 read col3", int'(dout), 32'h05A);
      rd(4);
      chk("R5 read col4", int'(dout), 32'h107);
      cyc(5'd4, 18'h3FFFF);
      chk("R3 precharge op", int'(bus_op), 3);
      chk("R3 precharge addr", int'(bus_addr), 32'h29400);

      sub(1, 1);
      chk("R6 select macro1", int'(macro_en), 2);
      cyc(5'd3, {8'hC3, 10'd3});
      rd(3);
      chk("R7 macro1 word", int'(dout), 32'h0C3);
      sub(1, 0);
      rd(3);
      chk("R7 macro0 word", int'(dout), 32'h05A);

      inject = 1'b1;
      rd(3);
      inject = 1'b0;
      chk("R5 corrupted word", int'(dout), 32'h15A);
      sub(2, 0);
      chk("R8 status parity", int'(dout), 1);

      cyc(5'd9, 18'h00003);
      chk("R9 no strobe", int'(bus_valid), 0);
      sub(2, 0);
      chk("R9 status illegal", int'(dout), 3);
      sub(1, 3);
      chk("R9 bad index keeps select", int'(macro_en), 1);
      sub(0, 0);
      sub(3, 0);
      sub(2, 0);
      chk("R8 status cleared", int'(dout), 0);

      cyc(5'd2, 18'd3);
      cyc(5'd5, 18'd0);
      cyc(5'd0, 18'h10000);
      chk("R8 read beats status", int'(dout), 32'h05A);

      inject = 1'b1;
      cyc(5'd2, 18'd3);
      cyc(5'd5, 18'd0);
      inject = 1'b0;
      cyc(5'd0, 18'h18000);
      sub(2, 0);
      chk("R8 set beats clear", int'(dout), 1);
      sub(3, 0);

      cyc(5'd1, 18'h000F0);
      sub(1, 2);
      chk("R6 select macro2", int'(macro_en), 4);
      tm_en = 1'b0;
      cyc(5'd2, 18'd5);
      chk("R1 enables off", int'(macro_en), 0);
      chk("R1 no strobe", int'(bus_valid), 0);
      chk("R1 dout cleared", int'(dout), 0);
      cyc(5'd2, 18'd5);
      chk("R1 still no strobe", int'(bus_valid), 0);
      tm_en = 1'b1;
      cyc(5'd0, 18'd0);
      chk("R1 select back to 0", int'(macro_en), 1);
      cyc(5'd2, 18'd5);
      chk("R1 row cleared", int'(bus_addr), 5);
      sub(2, 0);
      chk("R1 flags cleared", int'(dout), 0);
      cyc(5'd0, 18'd0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule